// File: doc/BRIEF.md
# Compare-Match Timer

This block is a 16-bit up-counter for timing intervals. It advances on a count-enable pulse that comes from a prescaler. The prescaler is set by a 3-bit select and either stops the timer or divides the system clock by 1, 8, 64, 256 or 1024. Software can load the count at any time through a write strobe. Counting then carries on from the loaded value at the following ticks.

A 16-bit compare register is held alongside the counter. A match event happens when a tick arrives while the count equals the compare value. On each match event the block does three things:

- It sets a sticky flag.
- If toggle-on-match is enabled, it inverts an output pin.
- If clear-on-match is enabled, it returns the counter to zero instead of incrementing it. This gives a period of compare value plus one ticks.

The interrupt request is the flag gated by an enable input. Software clears the flag with a one-cycle clear strobe. If a match event lands in the same cycle as the clear strobe, the event wins.

Top module: `cmp_timer`

## Requirements
- R1: After reset the count is 0, the flag is 0, the output pin is 0, the interrupt request is 0 and the compare register holds 16'hFFFF.
- R2: With prescaler select 0 the count holds its value.
- R3: Prescaler select codes 1, 2, 3, 4 and 5 advance the count once every 1, 8, 64, 256 and 1024 clock cycles respectively. The first advance happens on the Nth rising edge after the select leaves 0.
- R4: A count write loads the written value at the next clock edge and takes priority over a tick in that cycle. Counting resumes from the loaded value on later ticks.
- R5: A match event is a tick in a cycle where the count equals the compare register. It sets the flag at that clock edge.
- R6: With clear-on-match enabled, a match event loads 0 into the counter instead of incrementing it, so the period is compare value plus 1 ticks.
- R7: With toggle-on-match enabled, the output pin inverts on every match event. With it disabled, the pin holds its value.
- R8: A flag clear strobe clears the flag at the next edge. The flag then stays clear while the count keeps equalling the compare value with no tick.
- R9: A match event in the same cycle as a flag clear strobe leaves the flag set.
- R10: The interrupt request is high exactly when the flag is set and the interrupt enable input is high.
- R11: Without clear-on-match, the count wraps from 16'hFFFF to 0 on a tick.
- R12: A compare write loads the compare register at the next clock edge. Matches from then on use the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| psel_i | input | 3 | Prescaler select: 0 stop, 1..5 divide by 1/8/64/256/1024 |
| clr_on_match_i | input | 1 | Clear counter on match event |
| tgl_on_match_i | input | 1 | Toggle output pin on match event |
| irq_en_i | input | 1 | Interrupt enable |
| cnt_we_i | input | 1 | Count write strobe |
| cnt_wdata_i | input | 16 | Count write data |
| cmp_we_i | input | 1 | Compare register write strobe |
| cmp_wdata_i | input | 16 | Compare register write data |
| flag_clr_i | input | 1 | Flag clear strobe (write-one-to-clear) |
| cnt_o | output | 16 | Current count |
| oc_pin_o | output | 1 | Compare output pin |
| flag_o | output | 1 | Sticky compare flag |
| irq_o | output | 1 | Interrupt request |

## Verification
Two pairs of functions can collide in one cycle. The first pair is a match event and a software flag clear. The second pair is a tick and a count write. The first collision is provoked by stopping the timer with the count already equal to the compare value, clearing the flag, and then raising the clear strobe in the same cycle as the first tick. The flag must read set afterwards, and the counter must read 0 because clear-on-match is on. The second collision is provoked by writing the count while divide-by-1 is running; the written value must appear unchanged one cycle later, with no increment folded in.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned CNT_W = 16;
  localparam int unsigned PRE_W = 10;
  localparam int unsigned SEL_W = 3;

  typedef enum logic [SEL_W-1:0] {
    PS_STOP    = 3'd0,
    PS_DIV1    = 3'd1,
    PS_DIV8    = 3'd2,
    PS_DIV64   = 3'd3,
    PS_DIV256  = 3'd4,
    PS_DIV1024 = 3'd5
  } psel_e;

  // log2 of the division ratio for each select code
  function automatic int unsigned div_shift(logic [SEL_W-1:0] sel);
    case (sel)
      PS_DIV8:    return 3;
      PS_DIV64:   return 6;
      PS_DIV256:  return 8;
      PS_DIV1024: return 10;
      default:    return 0;
    endcase
  endfunction
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import tmr_pkg::*;
#(
  parameter int unsigned PW = PRE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] psel_i,
  output logic             tick_o
);
  logic [PW-1:0] div_q;
  logic [PW-1:0] mask;
  logic          run;

  assign run = (psel_i >= SEL_W'(PS_DIV1)) && (psel_i <= SEL_W'(PS_DIV1024));

  // low 'shift' bits set; tick when all of them are ones
  always_comb begin
    int unsigned sh;
    sh = div_shift(psel_i);
    for (int i = 0; i < PW; i++) mask[i] = (i < sh);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  div_q <= '0;
    else if (!run) div_q <= '0;
    else          div_q <= div_q + 1'b1;
  end

  assign tick_o = run && ((div_q & mask) == mask);
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
  import tmr_pkg::*;
#(
  parameter int unsigned W = CNT_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  input  logic         clr_hit_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (we_i)     cnt_q <= wdata_i;
    else if (tick_i) begin
      if (clr_hit_i)   cnt_q <= '0;
      else             cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/tmr_match.sv
module tmr_match
  import tmr_pkg::*;
#(
  parameter int unsigned W = CNT_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] cnt_i,
  input  logic         tick_i,
  input  logic         cmp_we_i,
  input  logic [W-1:0] cmp_wdata_i,
  input  logic         tgl_en_i,
  input  logic         flag_clr_i,
  output logic         eq_o,
  output logic         evt_o,
  output logic         flag_o,
  output logic         pin_o
);
  logic [W-1:0] cmp_q;
  logic         flag_q;
  logic         pin_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cmp_q <= '1;
    else if (cmp_we_i) cmp_q <= cmp_wdata_i;
  end

  assign eq_o  = (cnt_i == cmp_q);
  assign evt_o = tick_i && eq_o;

  // event beats clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         flag_q <= 1'b0;
    else if (evt_o)      flag_q <= 1'b1;
    else if (flag_clr_i) flag_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                pin_q <= 1'b0;
    else if (evt_o && tgl_en_i) pin_q <= ~pin_q;
  end

  assign flag_o = flag_q;
  assign pin_o  = pin_q;
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
  import tmr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] psel_i,
  input  logic             clr_on_match_i,
  input  logic             tgl_on_match_i,
  input  logic             irq_en_i,
  input  logic             cnt_we_i,
  input  logic [CNT_W-1:0] cnt_wdata_i,
  input  logic             cmp_we_i,
  input  logic [CNT_W-1:0] cmp_wdata_i,
  input  logic             flag_clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             oc_pin_o,
  output logic             flag_o,
  output logic             irq_o
);
  logic tick;
  logic match_eq;
  logic match_evt;

  tmr_prescaler #(.PW(PRE_W)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .psel_i (psel_i),
    .tick_o (tick)
  );

  tmr_counter #(.W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .we_i      (cnt_we_i),
    .wdata_i   (cnt_wdata_i),
    .clr_hit_i (clr_on_match_i && match_eq),
    .cnt_o     (cnt_o)
  );

  tmr_match #(.W(CNT_W)) u_match (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cnt_i       (cnt_o),
    .tick_i      (tick),
    .cmp_we_i    (cmp_we_i),
    .cmp_wdata_i (cmp_wdata_i),
    .tgl_en_i    (tgl_on_match_i),
    .flag_clr_i  (flag_clr_i),
    .eq_o        (match_eq),
    .evt_o       (match_evt),
    .flag_o      (flag_o),
    .pin_o       (oc_pin_o)
  );

  assign irq_o = flag_o && irq_en_i;
endmodule

// File: rtl/cmp_timer_chk.sv
module cmp_timer_chk
  import tmr_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic [SEL_W-1:0] psel_i,
  input logic             clr_on_match_i,
  input logic             tgl_on_match_i,
  input logic             cnt_we_i,
  input logic [CNT_W-1:0] cnt_wdata_i,
  input logic             flag_clr_i,
  input logic [CNT_W-1:0] cnt_o,
  input logic             oc_pin_o,
  input logic             flag_o,
  input logic             match_evt
);
  // R2
  stop_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (psel_i == '0 && !cnt_we_i) |=> $stable(cnt_o));

  // R4
  cnt_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_we_i |=> (cnt_o == $past(cnt_wdata_i)));

  // R5
  evt_sets_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_evt |=> flag_o);

  // R5
  flag_rise_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_o) |-> $past(match_evt));

  // R6
  clr_on_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_evt && clr_on_match_i && !cnt_we_i) |=> (cnt_o == '0));

  // R7
  pin_toggle_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(oc_pin_o) |-> ($past(match_evt) && $past(tgl_on_match_i)));

  // R8
  flag_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_clr_i && !match_evt) |=> !flag_o);
endmodule

bind cmp_timer cmp_timer_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .psel_i         (psel_i),
  .clr_on_match_i (clr_on_match_i),
  .tgl_on_match_i (tgl_on_match_i),
  .cnt_we_i       (cnt_we_i),
  .cnt_wdata_i    (cnt_wdata_i),
  .flag_clr_i     (flag_clr_i),
  .cnt_o          (cnt_o),
  .oc_pin_o       (oc_pin_o),
  .flag_o         (flag_o),
  .match_evt      (match_evt)
);

// File: tb/cmp_timer_test.sv
`timescale 1ns/1ps
module cmp_timer_test;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [15:0] wr;
    logic [2:0]  ps;
    logic [11:0] wait_n;
    logic [15:0] exp;
  } vec_t;

  // load value, select, cycles waited, expected count
  localparam vec_t VECS [6] = '{
    '{16'h0000, 3'd1, 12'd5,    16'h0005},
    '{16'h0010, 3'd2, 12'd16,   16'h0012},
    '{16'h0000, 3'd3, 12'd130,  16'h0002},
    '{16'h0000, 3'd4, 12'd255,  16'h0000},
    '{16'h0000, 3'd5, 12'd1024, 16'h0001},
    '{16'h0064, 3'd0, 12'd50,   16'h0064}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  psel = '0;
  logic        clr_en = 1'b0, tgl_en = 1'b0, irq_en = 1'b0;
  logic        cnt_we = 1'b0, cmp_we = 1'b0, flag_clr = 1'b0;
  logic [15:0] cnt_wd = '0, cmp_wd = '0;
  logic [15:0] cnt;
  logic        pin, flag, irq;
  int n_chk = 0, n_fail = 0;
  logic        pin_save;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmp_timer uut (
    .clk_i(clk), .rst_ni(rst_n), .psel_i(psel),
    .clr_on_match_i(clr_en), .tgl_on_match_i(tgl_en), .irq_en_i(irq_en),
    .cnt_we_i(cnt_we), .cnt_wdata_i(cnt_wd),
    .cmp_we_i(cmp_we), .cmp_wdata_i(cmp_wd),
    .flag_clr_i(flag_clr),
    .cnt_o(cnt), .oc_pin_o(pin), .flag_o(flag), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // stop, load count, optionally load compare, optionally clear flag
  task automatic setup(input logic [15:0] c, input logic wc, input logic [15:0] m, input logic fc);
    psel = 3'd0; cnt_we = 1'b1; cnt_wd = c;
    cmp_we = wc; cmp_wd = m; flag_clr = fc;
    cyc(1);
    cnt_we = 1'b0; cmp_we = 1'b0; flag_clr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    cyc(2);
    // R1 reset state
    chk("R1 cnt", 32'(cnt), 0);
    chk("R1 flag", 32'(flag), 0);
    chk("R1 pin", 32'(pin), 0);
    chk("R1 irq", 32'(irq), 0);
    rst_n = 1'b1;
    cyc(1);

    // R2 / R3 prescaler table
    foreach (VECS[i]) begin
      setup(VECS[i].wr, 1'b0, 16'h0, 1'b0);
      psel = VECS[i].ps;
      cyc(int'(VECS[i].wait_n));
      chk($sformatf("R3/R2 vec%0d", i), 32'(cnt), 32'(VECS[i].exp));
    end

    // R11 wrap
    setup(16'hFFFF, 1'b1, 16'h1234, 1'b1);
    chk("R1 cmp default gives no flag", 32'(flag), 0);
    psel = 3'd1; cyc(1);
    chk("R11 wrap", 32'(cnt), 0);
    chk("R11 no flag", 32'(flag), 0);

    // R5 R6 R7 R10 R12 periodic clear with toggle
    clr_en = 1'b1; tgl_en = 1'b1; irq_en = 1'b1;
    setup(16'h0, 1'b1, 16'h0005, 1'b1);
    psel = 3'd1;
    cyc(5);
    chk("R5 cnt at cmp", 32'(cnt), 5);
    chk("R5 no flag yet", 32'(flag), 0);
    cyc(1);
    chk("R6 clear", 32'(cnt), 0);
    chk("R5 flag set", 32'(flag), 1);
    chk("R7 pin toggled", 32'(pin), 1);
    chk("R10 irq on", 32'(irq), 1);
    cyc(6);
    chk("R6 period cmp+1", 32'(cnt), 0);
    chk("R7 pin back", 32'(pin), 0);
    psel = 3'd0; irq_en = 1'b0;
    #1;
    chk("R10 irq gated", 32'(irq), 0);
    irq_en = 1'b1;

    // R8 clear while equal and stopped
    setup(16'h0005, 1'b0, 16'h0, 1'b0);
    flag_clr = 1'b1; cyc(1); flag_clr = 1'b0;
    chk("R8 flag cleared", 32'(flag), 0);
    cyc(5);
    chk("R8 stays clear", 32'(flag), 0);
    chk("R8 cnt equal held", 32'(cnt), 5);

    // R9 event and clear in same cycle
    psel = 3'd1; flag_clr = 1'b1;
    cyc(1);
    flag_clr = 1'b0; psel = 3'd0;
    chk("R9 flag kept", 32'(flag), 1);
    chk("R9 cnt cleared", 32'(cnt), 0);
    chk("R7 pin toggled again", 32'(pin), 1);

    // R7 toggle disabled
    tgl_en = 1'b0;
    setup(16'h0005, 1'b0, 16'h0, 1'b0);
    pin_save = pin;
    psel = 3'd1; cyc(1); psel = 3'd0;
    chk("R7 pin held", 32'(pin), 32'(pin_save));
    chk("R5 flag by event", 32'(flag), 1);

    // R12 new compare value
    clr_en = 1'b0;
    setup(16'h0, 1'b1, 16'h0002, 1'b1);
    psel = 3'd1; cyc(2);
    chk("R12 before match", 32'(flag), 0);
    cyc(1);
    chk("R12 match on new cmp", 32'(flag), 1);
    chk("R12 cnt no clear", 32'(cnt), 3);

    // R4 write wins over tick while running
    cnt_we = 1'b1; cnt_wd = 16'h0100;
    cyc(1);
    cnt_we = 1'b0;
    chk("R4 loaded", 32'(cnt), 32'h100);
    cyc(1);
    chk("R4 resumes", 32'(cnt), 32'h101);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule